// File: doc/BRIEF.md
# USB Frame Interval Timer

This block keeps frame time for a full-speed USB host controller. Each enabled bit-time tick lowers a down-counter of the bit times left in the current 1 ms frame. After the counter has reached zero, the next tick starts a new frame. That tick reloads the counter from a programmable interval, advances a 16-bit frame number and raises a one-cycle start-of-frame pulse. A second one-cycle pulse marks each change of the top bit of the frame number, which lets software extend the frame count beyond 16 bits.

Software programs three values through write strobes: the interval word, the point in the frame at which periodic traffic gains priority, and the lowest remaining count at which a low-speed transaction may still begin. The interval word carries a toggle bit that flips on every rewrite. A reload copies this toggle into the remaining-time word, so a reader can tell when a new interval has taken effect. Two level flags compare the live count with the two programmed points. Scheduling of packets belongs to other logic.

Top module: `usb_frame_timer`

## Requirements
- R1: After reset, the remaining count, its toggle and the frame number are 0, the interval word reads 32'h0000_2EDF (interval 11999, packet size 0, toggle 0), both pulses are low, and both flags are high because the periodic point and the low-speed threshold reset to 0.
- R2: On a cycle where both run_en and bit_tick are high and the count is not zero, the count drops by one at that edge. A cycle where bit_tick is low leaves the count unchanged.
- R3: On a cycle where both run_en and bit_tick are high and the count is zero, the edge loads the count from the interval, increments the frame number (modulo 2^16) and sets sof_pulse for exactly the one following cycle. The frame number changes at no other time.
- R4: The interval word puts the interval in bits 13:0, the full-speed maximum packet size in bits 30:16 and the toggle in bit 31, with bits 15:14 reading 0. The remaining word uses bits 13:0 for the count and bit 31 for its toggle. Every interval write flips the toggle and ignores written bit 31. A reload copies the interval toggle into the remaining toggle.
- R5: An interval write leaves the running count untouched. The new interval takes effect at the next reload.
- R6: fno_pulse is high for the one cycle after a reload that changes bit 15 of the frame number, which happens from 16'h7FFF to 16'h8000 and from 16'hFFFF to 16'h0000. It is low at all other times.
- R7: prd_pri is high exactly while the count is less than or equal to the 14-bit periodic point.
- R8: ls_ok is high exactly while the count is greater than or equal to the 15-bit low-speed threshold.
- R9: While run_en is low, the count, its toggle and the frame number hold, even when bit_tick is high, and no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Allows the timer to advance |
| bit_tick | input | 1 | One bit time has elapsed |
| intv_wr | input | 1 | Write strobe for the interval word |
| intv_wdata | input | 32 | Interval word data |
| prd_wr | input | 1 | Write strobe for the periodic point |
| prd_wdata | input | 14 | Periodic point value |
| ls_wr | input | 1 | Write strobe for the low-speed threshold |
| ls_wdata | input | 15 | Low-speed threshold value |
| intv_q | output | 32 | Interval word readback |
| frm_remain | output | 32 | Remaining count and its toggle |
| frm_num | output | 16 | Frame number |
| sof_pulse | output | 1 | Start-of-frame pulse |
| fno_pulse | output | 1 | Frame-number top-bit change pulse |
| prd_pri | output | 1 | Periodic traffic has priority |
| ls_ok | output | 1 | A low-speed transaction may start |

## Verification
The overflow pulse is the hardest event to reach, because it needs 32768 and then 65536 frames. At the nominal interval that would take hundreds of millions of ticks. The stimulus programs an interval of zero, which makes every tick a new frame. It then ticks continuously through both top-bit changes and checks the frame number and the overflow pulse on every cycle. The two compare flags are checked at the exact equality points on each side, and the interval toggle is checked both in the interval word and after it is copied at the next reload.

// File: rtl/usb_frame_timer.sv
module usb_frame_timer #(
  parameter int FI_W    = 14,
  parameter int FS_W    = 15,
  parameter int FN_W    = 16,
  parameter int LS_W    = 15,
  parameter int FI_INIT = 11999
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_en,
  input  logic            bit_tick,
  input  logic            intv_wr,
  input  logic [31:0]     intv_wdata,
  input  logic            prd_wr,
  input  logic [FI_W-1:0] prd_wdata,
  input  logic            ls_wr,
  input  logic [LS_W-1:0] ls_wdata,
  output logic [31:0]     intv_q,
  output logic [31:0]     frm_remain,
  output logic [FN_W-1:0] frm_num,
  output logic            sof_pulse,
  output logic            fno_pulse,
  output logic            prd_pri,
  output logic            ls_ok
);

  localparam int FS_LSB = 16;
  localparam int CMP_W  = (FI_W > LS_W) ? FI_W : LS_W;

  logic [FI_W-1:0] fi_q, rem_q, ps_q;
  logic [FS_W-1:0] fs_q;
  logic [LS_W-1:0] lst_q;
  logic [FN_W-1:0] fn_q, fn_nxt;
  logic            itog_q, rtog_q, sof_q, fno_q;
  logic            adv, reload;

  assign adv    = run_en & bit_tick;
  assign reload = adv & (rem_q == '0);
  assign fn_nxt = fn_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fi_q   <= FI_W'(FI_INIT);
      fs_q   <= '0;
      itog_q <= 1'b0;
      ps_q   <= '0;
      lst_q  <= '0;
    end else begin
      if (intv_wr) begin
        fi_q   <= intv_wdata[FI_W-1:0];
        fs_q   <= intv_wdata[FS_LSB +: FS_W];
        itog_q <= ~itog_q;
      end
      if (prd_wr) ps_q  <= prd_wdata;
      if (ls_wr)  lst_q <= ls_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q  <= '0;
      rtog_q <= 1'b0;
      fn_q   <= '0;
      sof_q  <= 1'b0;
      fno_q  <= 1'b0;
    end else begin
      sof_q <= reload;
      fno_q <= reload & (fn_nxt[FN_W-1] != fn_q[FN_W-1]);
      if (reload) begin
        rem_q  <= fi_q;
        rtog_q <= itog_q;
        fn_q   <= fn_nxt;
      end else if (adv) begin
        rem_q <= rem_q - 1'b1;
      end
    end
  end

  always_comb begin
    intv_q = '0;
    intv_q[FI_W-1:0]     = fi_q;
    intv_q[FS_LSB +: FS_W] = fs_q;
    intv_q[31]           = itog_q;
    frm_remain = '0;
    frm_remain[FI_W-1:0] = rem_q;
    frm_remain[31]       = rtog_q;
  end

  assign frm_num   = fn_q;
  assign sof_pulse = sof_q;
  assign fno_pulse = fno_q;
  assign prd_pri   = rem_q <= ps_q;
  assign ls_ok     = CMP_W'(rem_q) >= CMP_W'(lst_q);

  assert_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && bit_tick && rem_q != '0) |=> rem_q == FI_W'($past(rem_q) - 1'b1));

  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sof_pulse |-> frm_remain[FI_W-1:0] == $past(fi_q));

  assert_fnum_only_sof_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(frm_num) |-> sof_pulse);

  assert_toggle_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    intv_wr |=> intv_q[31] != $past(intv_q[31]));

  assert_fno_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fno_pulse |-> (sof_pulse && frm_num[FN_W-2:0] == '0));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!sof_pulse && !fno_pulse && $stable(frm_remain) && $stable(frm_num)));

endmodule

// File: tb/test_usb_frame_timer.sv
module test_usb_frame_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0, bit_tick = 1'b0;
  logic        intv_wr = 1'b0, prd_wr = 1'b0, ls_wr = 1'b0;
  logic [31:0] intv_wdata = '0;
  logic [13:0] prd_wdata = '0;
  logic [14:0] ls_wdata = '0;
  logic [31:0] intv_q, frm_remain;
  logic [15:0] frm_num;
  logic        sof_pulse, fno_pulse, prd_pri, ls_ok;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    int          sel;
    logic [31:0] val;
    string       req;
  } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  usb_frame_timer i_usb_frame_timer (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .bit_tick(bit_tick),
    .intv_wr(intv_wr), .intv_wdata(intv_wdata),
    .prd_wr(prd_wr), .prd_wdata(prd_wdata),
    .ls_wr(ls_wr), .ls_wdata(ls_wdata),
    .intv_q(intv_q), .frm_remain(frm_remain), .frm_num(frm_num),
    .sof_pulse(sof_pulse), .fno_pulse(fno_pulse),
    .prd_pri(prd_pri), .ls_ok(ls_ok)
  );

  // sel: 0 remain, 1 interval, 2 frame number, 3 sof, 4 fno, 5 periodic, 6 low-speed
  function automatic logic [31:0] pick(int sel);
    case (sel)
      0: return frm_remain;
      1: return intv_q;
      2: return {16'h0, frm_num};
      3: return {31'h0, sof_pulse};
      4: return {31'h0, fno_pulse};
      5: return {31'h0, prd_pri};
      default: return {31'h0, ls_ok};
    endcase
  endfunction

  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      act = pick(it.sel);
      checks++;
      if (act !== it.val) begin
        errors++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.val);
      end
    end
  end

  task automatic expect_out(int sel, logic [31:0] val, string req);
    item_t it;
    it.sel = sel; it.val = val; it.req = req;
    sb.push_back(it);
  endtask

  task automatic cyc(logic t, logic r);
    @(negedge clk);
    bit_tick = t; run_en = r;
    intv_wr = 0; prd_wr = 0; ls_wr = 0;
    @(posedge clk); #1;
  endtask

  task automatic wr_intv(logic [31:0] d);
    @(negedge clk);
    bit_tick = 0; intv_wr = 1; intv_wdata = d;
    @(posedge clk); #1;
    intv_wr = 0;
  endtask

  task automatic wr_thr(logic [13:0] p, logic [14:0] l);
    @(negedge clk);
    bit_tick = 0; prd_wr = 1; prd_wdata = p; ls_wr = 1; ls_wdata = l;
    @(posedge clk); #1;
    prd_wr = 0; ls_wr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] bfn;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    expect_out(0, 32'h0, "R1"); expect_out(1, 32'h0000_2EDF, "R1");
    expect_out(2, 32'h0, "R1"); expect_out(3, 0, "R1"); expect_out(4, 0, "R1");
    expect_out(5, 1, "R1"); expect_out(6, 1, "R1");

    wr_intv(32'h8123_0005);
    expect_out(1, 32'h8123_0005, "R4 toggle flips to 1");
    expect_out(0, 32'h0, "R5 write leaves count");

    cyc(1, 1);
    expect_out(0, 32'h8000_0005, "R3 R4 reload copies interval and toggle");
    expect_out(2, 1, "R3 frame number"); expect_out(3, 1, "R3 sof");
    expect_out(4, 0, "R6 no fno");
    cyc(1, 1);
    expect_out(0, 32'h8000_0004, "R2 decrement"); expect_out(3, 0, "R3 sof one cycle");
    cyc(1, 0);
    expect_out(0, 32'h8000_0004, "R9 hold"); expect_out(3, 0, "R9 no sof");
    cyc(0, 1);
    expect_out(0, 32'h8000_0004, "R2 no tick no change");

    wr_thr(14'd2, 15'd3);
    expect_out(5, 0, "R7 count 4 above point"); expect_out(6, 1, "R8 count 4 above threshold");
    cyc(1, 1);
    expect_out(0, 32'h8000_0003, "R2");
    expect_out(5, 0, "R7 count 3"); expect_out(6, 1, "R8 equal threshold");
    cyc(1, 1);
    expect_out(5, 1, "R7 equal point"); expect_out(6, 0, "R8 below threshold");

    wr_intv(32'h8000_0007);
    expect_out(1, 32'h0000_0007, "R4 bit31 ignored toggle back to 0");
    expect_out(0, 32'h8000_0002, "R5 count untouched");
    cyc(1, 1); cyc(1, 1);
    expect_out(0, 32'h8000_0000, "R2 reach zero");
    cyc(1, 0);
    expect_out(0, 32'h8000_0000, "R9 hold at zero");
    expect_out(2, 1, "R9 frame number holds"); expect_out(3, 0, "R9 no sof");
    cyc(1, 1);
    expect_out(0, 32'h0000_0007, "R5 new interval at reload");
    expect_out(2, 2, "R3 frame number"); expect_out(3, 1, "R3 sof");

    wr_intv(32'h0000_0000);
    expect_out(1, 32'h8000_0000, "R4 toggle flips to 1");
    for (int i = 0; i < 7; i++) cyc(1, 1);
    expect_out(0, 32'h0000_0000, "R2 count to zero");
    bfn = 16'd2;
    for (int i = 0; i < 65540; i++) begin
      cyc(1, 1);
      bfn = bfn + 16'd1;
      expect_out(2, {16'h0, bfn}, "R3 frame number per frame");
      expect_out(4, {31'h0, (bfn[14:0] == 15'h0)}, "R6 fno on bit15 change");
    end
    expect_out(0, 32'h8000_0000, "R4 toggle copied at zero interval");

    cyc(0, 0); cyc(0, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule